// File: doc/BRIEF.md
# Core-local timer and software-interrupt unit

This block gives one processor core a wall-clock time base and two interrupt lines. It holds a 64-bit counter that steps by one on every cycle in which the single-cycle `tick` enable is high. Beside the counter sit a 64-bit compare value and a one-bit software-interrupt flag. `timer_irq` rises once the counter has reached the compare value. The test treats both values as points on a circle, so a counter that has wrapped past zero is still ordered correctly. `soft_irq` mirrors the stored flag. The nominal tick rate is 65 MHz, which is produced outside the block.

Software reaches the block over a plain 32-bit register bus. It drives valid, write, an access size, a byte address and write data. It receives read data and a two-bit response code in the same cycle. A write takes effect at the clock edge that ends the request. The counter and the compare value are each reached as two 32-bit halves. Writing a counter half rebases the time base: counting carries on from the new value.

Top module: `hart_timer_unit`

## Requirements
- R1: After reset the counter reads 0, both compare halves read 0xFFFFFFFF, the software flag reads 0, and both interrupt outputs are low. `timer_irq` stays low until some compare half has been written.
- R2: The counter steps by exactly one at each clock edge where `tick` is high, and holds its value where `tick` is low.
- R3: A word write to a counter half replaces only that half and keeps the other. A counter write wins over a `tick` in the same cycle. A later tick increments the full 64-bit result, carrying from the low half into the high half.
- R4: A word write to a compare half replaces only that half. The other half keeps its value, and both halves read back what was written.
- R5: A word write to the software flag stores 1 for any nonzero data and 0 for zero data, and a read returns that bit in bit 0. `soft_irq` equals the stored bit from the next clock edge on.
- R6: Once a compare half has been written, `timer_irq` at each edge takes the value of the following test on the state before that edge: d = compare − counter (mod 2^64) is zero or has bit 63 set. In particular, `timer_irq` is high the edge after the counter becomes equal to the compare value.
- R7: A request with `req_size` other than 2 (0 = byte, 1 = halfword, 3 is treated alike) returns `rsp_err` = 1 (misaligned) and read data 0. It changes no register.
- R8: A word request to a byte address outside the register map returns `rsp_err` = 2 (access fault) and read data 0, and changes no register. An address that is not a multiple of four is outside the map.
- R9: The register map uses byte addresses: 0x0000 is the software flag, 0x4000 and 0x4004 are the compare low and high halves, and 0x7FF8 and 0x7FFC are the counter low and high halves. A successful access returns `rsp_err` = 0, and a successful write returns read data 0.
- R10: The comparison is wrap-safe. With counter 0xFFFFFFFF_FFFFFFFE and compare 2, `timer_irq` stays low. After four ticks the counter reads 2 and `timer_irq` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle time-base enable |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address within the block |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, same cycle as the request |
| rsp_err | output | 2 | 0 ok, 1 misaligned, 2 access fault |
| timer_irq | output | 1 | Registered timer interrupt level |
| soft_irq | output | 1 | Registered software interrupt level |

## Verification
The bench builds the block with its defaults, DATA_W = 32 and ADDR_W = 16. At these values the full register map is decodable and the counter and compare halves line up with the bus word. Because the counter can be rebased, the bench loads values close to the 32-bit carry and close to the 64-bit wrap. That puts the low-to-high carry and the wrap-safe comparison within a few ticks of each other, with no long count needed.

// File: rtl/htu_pkg.sv
package htu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_MISALIGN = 2'd1,
    RSP_FAULT    = 2'd2
  } rsp_code_e;

  typedef enum logic [2:0] {
    SEL_FLAG   = 3'd0,
    SEL_CMP_LO = 3'd1,
    SEL_CMP_HI = 3'd2,
    SEL_CNT_LO = 3'd3,
    SEL_CNT_HI = 3'd4,
    SEL_NONE   = 3'd5
  } reg_sel_e;

  // byte addresses of the register words
  localparam logic [31:0] OFF_FLAG   = 32'h0000_0000;
  localparam logic [31:0] OFF_CMP_LO = 32'h0000_4000;
  localparam logic [31:0] OFF_CMP_HI = 32'h0000_4004;
  localparam logic [31:0] OFF_CNT_LO = 32'h0000_7FF8;
  localparam logic [31:0] OFF_CNT_HI = 32'h0000_7FFC;

endpackage

// File: rtl/htu_decode.sv
module htu_decode
  import htu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output reg_sel_e          sel,
  output rsp_code_e         err,
  output logic              wr_en
);

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [31:0] off);
    return a == off[ADDR_W-1:0];
  endfunction

  always_comb begin
    if (at(req_addr, OFF_FLAG))        sel = SEL_FLAG;
    else if (at(req_addr, OFF_CMP_LO)) sel = SEL_CMP_LO;
    else if (at(req_addr, OFF_CMP_HI)) sel = SEL_CMP_HI;
    else if (at(req_addr, OFF_CNT_LO)) sel = SEL_CNT_LO;
    else if (at(req_addr, OFF_CNT_HI)) sel = SEL_CNT_HI;
    else                               sel = SEL_NONE;
  end

  always_comb begin
    if (!req_valid)                   err = RSP_OK;
    else if (req_size != 2'(SZ_WORD)) err = RSP_MISALIGN;
    else if (sel == SEL_NONE)         err = RSP_FAULT;
    else                              err = RSP_OK;
  end

  assign wr_en = req_valid && req_write && (err == RSP_OK);

endmodule

// File: rtl/htu_counter.sv
module htu_counter #(
  parameter int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [TIME_W-1:0] cnt_q,
  output logic              cnt_wr
);

  function automatic logic [TIME_W-1:0] step(input logic [TIME_W-1:0] v);
    return v + TIME_W'(1);
  endfunction

  assign cnt_wr = wr_lo || wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (wr_lo) cnt_q[DATA_W-1:0]      <= wdata;
      if (wr_hi) cnt_q[TIME_W-1:DATA_W] <= wdata;
    end else if (tick) begin
      cnt_q <= step(cnt_q);
    end
  end

endmodule

// File: rtl/htu_compare_irq.sv
module htu_compare_irq #(
  parameter int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_half,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TIME_W-1:0] cnt,
  output logic [TIME_W-1:0] cmp_q,
  output logic              armed_q,
  output logic              due_now,
  output logic              timer_irq
);

  logic [1:0][DATA_W-1:0] half_q;

  function automatic logic is_due(input logic [TIME_W-1:0] c, input logic [TIME_W-1:0] t);
    logic [TIME_W-1:0] d;
    d = c - t;
    return (d == '0) || d[TIME_W-1];
  endfunction

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)          half_q[h] <= '1;
      else if (wr_half[h]) half_q[h] <= wdata;
    end
  end

  assign cmp_q   = half_q;
  assign due_now = is_due(cmp_q, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      timer_irq <= 1'b0;
    end else begin
      if (|wr_half) armed_q <= 1'b1;
      timer_irq <= armed_q && due_now;
    end
  end

endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
  import htu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_err,
  output logic              timer_irq,
  output logic              soft_irq
);

  localparam int TIME_W = 2 * DATA_W;

  reg_sel_e          sel;
  rsp_code_e         err;
  logic              wr_en;
  logic [TIME_W-1:0] cnt_q;
  logic              cnt_wr;
  logic [TIME_W-1:0] cmp_q;
  logic              armed_q;
  logic              due_now;
  logic              flag_q;
  logic              wr_flag, wr_cnt_lo, wr_cnt_hi;
  logic [1:0]        wr_cmp;

  htu_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .sel       (sel),
    .err       (err),
    .wr_en     (wr_en)
  );

  assign wr_flag   = wr_en && (sel == SEL_FLAG);
  assign wr_cmp[0] = wr_en && (sel == SEL_CMP_LO);
  assign wr_cmp[1] = wr_en && (sel == SEL_CMP_HI);
  assign wr_cnt_lo = wr_en && (sel == SEL_CNT_LO);
  assign wr_cnt_hi = wr_en && (sel == SEL_CNT_HI);

  htu_counter #(.DATA_W(DATA_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_lo  (wr_cnt_lo),
    .wr_hi  (wr_cnt_hi),
    .wdata  (req_wdata),
    .cnt_q  (cnt_q),
    .cnt_wr (cnt_wr)
  );

  htu_compare_irq #(.DATA_W(DATA_W)) u_compare (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_half   (wr_cmp),
    .wdata     (req_wdata),
    .cnt       (cnt_q),
    .cmp_q     (cmp_q),
    .armed_q   (armed_q),
    .due_now   (due_now),
    .timer_irq (timer_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      soft_irq <= 1'b0;
    end else begin
      if (wr_flag) flag_q <= |req_wdata;
      soft_irq <= flag_q;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (req_valid && !req_write && err == RSP_OK) begin
      unique case (sel)
        SEL_FLAG:   rsp_rdata = {{(DATA_W-1){1'b0}}, flag_q};
        SEL_CMP_LO: rsp_rdata = cmp_q[DATA_W-1:0];
        SEL_CMP_HI: rsp_rdata = cmp_q[TIME_W-1:DATA_W];
        SEL_CNT_LO: rsp_rdata = cnt_q[DATA_W-1:0];
        SEL_CNT_HI: rsp_rdata = cnt_q[TIME_W-1:DATA_W];
        default:    rsp_rdata = '0;
      endcase
    end
  end

  assign rsp_err = err;

endmodule

// File: rtl/htu_checker.sv
module htu_checker #(
  parameter int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              req_valid,
  input logic [1:0]        req_size,
  input logic [1:0]        rsp_err,
  input logic [TIME_W-1:0] cnt,
  input logic              cnt_wr,
  input logic [TIME_W-1:0] cmp,
  input logic              flag,
  input logic              armed,
  input logic              timer_irq,
  input logic              soft_irq
);

  // counter has reached compare when compare is not strictly ahead
  function automatic logic reached(input logic [TIME_W-1:0] c, input logic [TIME_W-1:0] t);
    return !($signed(c - t) > 0);
  endfunction

  p_unarmed_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !timer_irq);

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr |=> cnt == $past(cnt) + TIME_W'(1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(cnt));

  p_soft_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> soft_irq == $past(flag));

  p_timer_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> timer_irq == ($past(armed) && reached($past(cmp), $past(cnt))));

  p_narrow_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size != 2'd2 |-> rsp_err == 2'd1);

  p_narrow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size != 2'd2 |=> $stable(cmp) && $stable(flag));

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_err == 2'd2 |=> $stable(cmp) && $stable(flag));

endmodule

bind hart_timer_unit htu_checker #(.DATA_W(DATA_W)) u_htu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .req_valid (req_valid),
  .req_size  (req_size),
  .rsp_err   (rsp_err),
  .cnt       (cnt_q),
  .cnt_wr    (cnt_wr),
  .cmp       (cmp_q),
  .flag      (flag_q),
  .armed     (armed_q),
  .timer_irq (timer_irq),
  .soft_irq  (soft_irq)
);

// File: tb/hart_timer_unit_test.sv
module hart_timer_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_err;
  logic        timer_irq, soft_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_timer_unit uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .timer_irq(timer_irq), .soft_irq(soft_irq)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [1:0]  er;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd2, 16'h4000, 32'h0,        32'hFFFF_FFFF, 2'd0}, // R1 R9
    '{1'b0, 2'd2, 16'h4004, 32'h0,        32'hFFFF_FFFF, 2'd0}, // R1
    '{1'b0, 2'd2, 16'h7FF8, 32'h0,        32'h0,         2'd0}, // R1
    '{1'b0, 2'd2, 16'h0000, 32'h0,        32'h0,         2'd0}, // R1
    '{1'b1, 2'd2, 16'h4000, 32'h0000_0100, 32'h0,        2'd0}, // R4
    '{1'b0, 2'd2, 16'h4000, 32'h0,        32'h0000_0100, 2'd0}, // R4
    '{1'b0, 2'd2, 16'h4004, 32'h0,        32'hFFFF_FFFF, 2'd0}, // R4 other half kept
    '{1'b1, 2'd2, 16'h4004, 32'h0,        32'h0,         2'd0}, // R4
    '{1'b0, 2'd2, 16'h4000, 32'h0,        32'h0000_0100, 2'd0}, // R4
    '{1'b1, 2'd2, 16'h0000, 32'h0000_0005, 32'h0,        2'd0}, // R5 nonzero
    '{1'b0, 2'd2, 16'h0000, 32'h0,        32'h0000_0001, 2'd0}, // R5
    '{1'b1, 2'd0, 16'h0000, 32'h0,        32'h0,         2'd1}, // R7 byte write
    '{1'b0, 2'd2, 16'h0000, 32'h0,        32'h0000_0001, 2'd0}, // R7 unchanged
    '{1'b0, 2'd1, 16'h4000, 32'h0,        32'h0,         2'd1}, // R7 halfword read
    '{1'b1, 2'd2, 16'h1234, 32'hDEAD_BEEF, 32'h0,        2'd2}, // R8
    '{1'b0, 2'd2, 16'h4008, 32'h0,        32'h0,         2'd2}, // R8
    '{1'b1, 2'd2, 16'h7FF8, 32'h0000_0011, 32'h0,        2'd0}, // R3
    '{1'b0, 2'd2, 16'h7FF8, 32'h0,        32'h0000_0011, 2'd0}, // R3
    '{1'b0, 2'd2, 16'h7FFC, 32'h0,        32'h0,         2'd0}, // R3 other half kept
    '{1'b1, 2'd2, 16'h0000, 32'h0,        32'h0,         2'd0}, // R5 zero clears
    '{1'b1, 2'd2, 16'h7FFA, 32'h0000_0099, 32'h0,        2'd2}, // R8 unaligned word
    '{1'b0, 2'd2, 16'h7FF8, 32'h0,        32'h0000_0011, 2'd0}  // R8 unchanged
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic bus(input logic w, input logic [1:0] sz, input logic [15:0] a,
                     input logic [31:0] wd, output logic [31:0] rd, output logic [1:0] er);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    #1;
    rd = rsp_rdata; er = rsp_err;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic wr32(input logic [15:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic [1:0] er;
    bus(1'b1, 2'd2, a, wd, rd, er);
  endtask

  task automatic rd32(input logic [15:0] a, output logic [31:0] rd);
    logic [1:0] er;
    bus(1'b0, 2'd2, a, 32'h0, rd, er);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  er;
    rst_n = 1'b0; tick = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 timer_irq after reset", 64'(timer_irq), 64'd0);
    check("R1 soft_irq after reset", 64'(soft_irq), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      bus(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd, rd, er);
      check($sformatf("R9 table vec %0d rdata", i), 64'(rd), 64'(VECS[i].rd));
      check($sformatf("R9 table vec %0d err", i), 64'(er), 64'(VECS[i].er));
    end
    @(negedge clk);
    check("R6 compare ahead keeps timer low", 64'(timer_irq), 64'd0);

    // R2: five ticks, then hold
    ticks(5);
    rd32(16'h7FF8, rd);
    check("R2 count after five ticks", 64'(rd), 64'h16);
    repeat (3) @(negedge clk);
    rd32(16'h7FF8, rd);
    check("R2 hold without tick", 64'(rd), 64'h16);

    // R5: soft_irq latency
    wr32(16'h0000, 32'h8000_0000);
    check("R5 soft_irq not yet", 64'(soft_irq), 64'd0);
    @(negedge clk);
    check("R5 soft_irq set", 64'(soft_irq), 64'd1);
    wr32(16'h0000, 32'h0);
    @(negedge clk);
    check("R5 soft_irq cleared", 64'(soft_irq), 64'd0);

    // R6: equality reached by a tick
    wr32(16'h4000, 32'h20);
    wr32(16'h7FF8, 32'h1F);
    @(negedge clk);
    check("R6 one below compare", 64'(timer_irq), 64'd0);
    ticks(1);
    check("R6 irq one edge after equality not yet", 64'(timer_irq), 64'd0);
    @(negedge clk);
    check("R6 irq at equality", 64'(timer_irq), 64'd1);
    wr32(16'h4000, 32'h30);
    @(negedge clk);
    check("R6 irq drops when compare moves ahead", 64'(timer_irq), 64'd0);

    // R3: carry from low into high half
    wr32(16'h7FF8, 32'hFFFF_FFFF);
    wr32(16'h7FFC, 32'h7);
    ticks(1);
    rd32(16'h7FF8, rd);
    check("R3 low half after carry", 64'(rd), 64'h0);
    rd32(16'h7FFC, rd);
    check("R3 high half after carry", 64'(rd), 64'h8);

    // R3: write wins over same-cycle tick
    tick = 1'b1;
    wr32(16'h7FF8, 32'h55);
    tick = 1'b0;
    rd32(16'h7FF8, rd);
    check("R3 write beats tick", 64'(rd), 64'h55);
    rd32(16'h7FFC, rd);
    check("R3 high half kept", 64'(rd), 64'h8);

    // R10: wrap-safe comparison
    wr32(16'h4000, 32'h2);
    wr32(16'h4004, 32'h0);
    wr32(16'h7FFC, 32'hFFFF_FFFF);
    wr32(16'h7FF8, 32'hFFFF_FFFE);
    @(negedge clk);
    @(negedge clk);
    check("R10 wrapped compare ahead, irq low", 64'(timer_irq), 64'd0);
    ticks(4);
    @(negedge clk);
    check("R10 irq after wrap to compare", 64'(timer_irq), 64'd1);
    rd32(16'h7FF8, rd);
    check("R10 counter low after wrap", 64'(rd), 64'h2);
    rd32(16'h7FFC, rd);
    check("R10 counter high after wrap", 64'(rd), 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule